// File: doc/BRIEF.md
# Policy-Configurable Countdown Timer

This block is a down-counter that steps once every prescaled tick, where the tick period is a number of clock cycles held in a register. It has three modes: off, repeating, and single-shot. When a repeating run expires, the count is refilled from a limit register. When a single-shot run expires, the timer switches itself off at zero. A set of single-cycle control strobes lets the surrounding logic do the following:

- write the limit, optionally copying it into the count;
- write the count directly;
- start in either mode;
- stop;
- change the tick period.

The live count and the mode are always visible on the outputs, and every expiry produces a one-cycle fire pulse.

A static policy vector changes what happens around a count of zero. It can add a one-tick dwell at zero before each refill, keep firing on every tick when the limit is zero, or delay the fire that a zero arm would cause by one tick. It can also hold a zero count for one tick before refilling, or allow fire pulses only on a real decrement to zero. Arming means starting from off, or writing the count, or writing the limit with refill while running. Arming with a count of zero is resolved in a single cycle, using these policies.

Top module: `cdt_timer`

## Requirements
- R1: After reset, count_o is 0, mode_o is 0 (off), fire_o is 0, and the limit and tick period registers are 0.
- R2: mode_o encodes 0 as off, 1 as repeating and 2 as single-shot. While the timer runs with tick period P, the count drops by one P cycles after it was armed and every P cycles after that. In repeating mode, a tick at count 1 loads the limit and raises fire_o for one cycle in that same clock.
- R3: In single-shot mode, a tick at count 1 sets the count to 0 and mode_o to 0, and gives exactly one fire pulse.
- R4: A limit write with limit_reload_i set also loads the count with the new limit. With limit_reload_i clear, only the limit changes: the count is untouched, and the next refill uses the new limit.
- R5: stop_i sets mode_o to 0 and keeps the count unchanged while off. A later start counts down from that kept value.
- R6: A start while the tick period is 0 is ignored. A running timer whose period becomes 0 turns itself off on the next clock and keeps its count.
- R7: Policy bit 0 (dwell) makes a repeating timer fire on reaching 0, stay at 0 for one tick, and only then load the limit, with no second fire. A full cycle is therefore limit+1 ticks.
- R8: Policy bit 1 (continuous) makes a repeating timer armed with count 0 and limit 0 stay on and fire on every tick. Without it, that timer turns off.
- R9: Policy bit 2 (late fire) means arming with count 0 gives no fire. The count stays 0, and the next tick fires and loads the limit.
- R10: Policy bit 3 (late refill) means arming a repeating timer with count 0 and a nonzero limit fires at once and holds 0 for one tick. The following tick loads the limit without firing.
- R11: Policy bit 4 (decrement-only) suppresses the fire caused by arming at count 0; only a tick from count 1 fires. Bits 2 and 4 set together are an illegal setting.
- R12: With no policy bits set, arming at count 0 fires on the next clock and loads the limit at once. If the limit is also 0, the timer turns off instead.
- R13: A period write while running keeps the count. The next tick comes a full new period after the write.
- R14: Any control strobe in a cycle suppresses that cycle's tick. A count write that lands on a tick edge loads the written value, gives no fire, and restarts the tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| policy_i | input | 5 | Static policy vector; bit positions as in R7 to R11 |
| limit_we_i | input | 1 | Limit write strobe |
| limit_reload_i | input | 1 | With a limit write, also load the count |
| limit_i | input | CNT_W | New limit value |
| count_we_i | input | 1 | Count write strobe |
| count_i | input | CNT_W | New count value |
| start_i | input | 1 | Start strobe |
| start_single_i | input | 1 | With start, select single-shot (else repeating) |
| stop_i | input | 1 | Stop strobe |
| period_we_i | input | 1 | Tick period write strobe |
| period_i | input | PER_W | New tick period in clock cycles |
| count_o | output | CNT_W | Live count |
| mode_o | output | 2 | Current mode (0 off, 1 repeating, 2 single-shot) |
| fire_o | output | 1 | One-cycle expiry pulse |

## Verification
The properties take three things for granted about the inputs. At most one control strobe is high in any cycle. Policy bits 2 and 4 are never set together. The policy vector changes only while the timer is off. The stimulus keeps within this by sending every strobe through one task that drives exactly one strobe for exactly one clock. It changes the policy only after a stop has taken effect and never selects the illegal pair. Expected fire cycles are computed from the arm cycle and the period and queued ahead of time, so any early, late or extra pulse is caught.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   typedef enum logic [1:0] {
      MODE_OFF      = 2'd0,
      MODE_PERIODIC = 2'd1,
      MODE_ONESHOT  = 2'd2
   } cdt_mode_e;

   localparam int POL_W           = 5;
   localparam int POL_DWELL       = 0;
   localparam int POL_CONT        = 1;
   localparam int POL_LATE_TRIG   = 2;
   localparam int POL_LATE_RELOAD = 3;
   localparam int POL_DEC_ONLY    = 4;

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
   parameter int PER_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             hold_i,
   input  logic             restart_i,
   input  logic [PER_W-1:0] period_i,
   output logic             tick_o
);

   logic [PER_W-1:0] phase_q;
   logic             at_end;
   logic             per_zero;

   assign per_zero = (period_i == '0);
   assign at_end   = (phase_q == period_i - 1'b1);
   assign tick_o   = run_i && !hold_i && !per_zero && at_end;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else if (!run_i || restart_i || per_zero || tick_o) begin
         phase_q <= '0;
      end else if (!hold_i) begin
         phase_q <= phase_q + 1'b1;
      end
   end

   // R13: the phase never escapes the programmed period
   p_phase_in_range_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_i != '0) |-> (phase_q < period_i));

endmodule

// File: rtl/cdt_arm.sv
module cdt_arm
   import cdt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [POL_W-1:0] policy_i,
   input  logic [CNT_W-1:0] val_i,
   input  logic [CNT_W-1:0] lim_i,
   input  cdt_mode_e        mode_i,
   output logic [CNT_W-1:0] count_o,
   output cdt_mode_e        mode_o,
   output logic             defer_o,
   output logic             fire_o
);

   logic lim_zero;
   logic keep_zero;

   assign lim_zero  = (lim_i == '0);
   assign keep_zero = (mode_i == MODE_PERIODIC) &&
                      ((policy_i[POL_LATE_RELOAD] && !lim_zero) ||
                       (policy_i[POL_CONT] && lim_zero));

   always_comb begin
      count_o = val_i;
      mode_o  = mode_i;
      defer_o = 1'b0;
      fire_o  = 1'b0;
      if (val_i == '0) begin
         if (policy_i[POL_LATE_TRIG]) begin
            defer_o = 1'b1;
         end else begin
            fire_o = !policy_i[POL_DEC_ONLY];
            if (!policy_i[POL_LATE_RELOAD] && !lim_zero) begin
               count_o = lim_i;
            end else if (!keep_zero) begin
               mode_o = MODE_OFF;
            end
         end
      end
   end

endmodule

// File: rtl/cdt_core.sv
module cdt_core
   import cdt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PER_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [POL_W-1:0] policy_i,
   input  logic             limit_we_i,
   input  logic             limit_reload_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             count_we_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             start_i,
   input  logic             start_single_i,
   input  logic             stop_i,
   input  logic             period_we_i,
   input  logic [PER_W-1:0] period_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o,
   output cdt_mode_e        mode_o,
   output logic             fire_o,
   output logic             run_o,
   output logic             hold_o,
   output logic             restart_o,
   output logic [PER_W-1:0] period_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cdt_mode_e        mode_q, mode_d, req_mode, arm_mode, a_mode;
   logic [CNT_W-1:0] count_q, count_d, limit_q, limit_d;
   logic [CNT_W-1:0] arm_val, arm_lim, a_count;
   logic [PER_W-1:0] period_q, period_d;
   logic             defer_q, defer_d, fire_q, fire_d;
   logic             a_defer, a_fire, running, restart;

   assign running  = (mode_q != MODE_OFF);
   assign req_mode = start_single_i ? MODE_ONESHOT : MODE_PERIODIC;

   // operands of the zero-count decision for the strobe in this cycle
   always_comb begin
      arm_val  = count_q;
      arm_lim  = limit_q;
      arm_mode = req_mode;
      if (start_i) begin
         arm_mode = req_mode;
      end else if (count_we_i) begin
         arm_val  = count_i;
         arm_mode = mode_q;
      end else if (limit_we_i) begin
         arm_val  = limit_i;
         arm_lim  = limit_i;
         arm_mode = mode_q;
      end
   end

   cdt_arm #(.CNT_W(CNT_W)) arm_i (
      .policy_i (policy_i),
      .val_i    (arm_val),
      .lim_i    (arm_lim),
      .mode_i   (arm_mode),
      .count_o  (a_count),
      .mode_o   (a_mode),
      .defer_o  (a_defer),
      .fire_o   (a_fire)
   );

   always_comb begin
      mode_d   = mode_q;
      count_d  = count_q;
      limit_d  = limit_q;
      period_d = period_q;
      defer_d  = defer_q;
      fire_d   = 1'b0;
      restart  = 1'b0;
      if (stop_i) begin
         mode_d  = MODE_OFF;
         defer_d = 1'b0;
      end else if (start_i) begin
         if (!running) begin
            if (period_q != '0) begin
               count_d = a_count;
               mode_d  = a_mode;
               defer_d = a_defer;
               fire_d  = a_fire;
               restart = 1'b1;
            end
         end else begin
            mode_d = req_mode;
         end
      end else if (count_we_i) begin
         if (running) begin
            count_d = a_count;
            mode_d  = a_mode;
            defer_d = a_defer;
            fire_d  = a_fire;
            restart = 1'b1;
         end else begin
            count_d = count_i;
            defer_d = 1'b0;
         end
      end else if (limit_we_i) begin
         limit_d = limit_i;
         if (limit_reload_i) begin
            if (running) begin
               count_d = a_count;
               mode_d  = a_mode;
               defer_d = a_defer;
               fire_d  = a_fire;
               restart = 1'b1;
            end else begin
               count_d = limit_i;
               defer_d = 1'b0;
            end
         end
      end else if (period_we_i) begin
         period_d = period_i;
         restart  = 1'b1;
      end else if (running && period_q == '0) begin
         mode_d = MODE_OFF;
      end else if (tick_i) begin
         if (count_q > ONE) begin
            count_d = count_q - ONE;
         end else if (count_q == ONE) begin
            fire_d = 1'b1;
            if (mode_q == MODE_ONESHOT) begin
               count_d = '0;
               mode_d  = MODE_OFF;
            end else if (policy_i[POL_DWELL]) begin
               count_d = '0;
            end else begin
               count_d = limit_q;
               if (limit_q == '0 && !policy_i[POL_CONT]) mode_d = MODE_OFF;
            end
         end else begin
            fire_d  = defer_q || (policy_i[POL_CONT] && limit_q == '0 &&
                                  mode_q == MODE_PERIODIC);
            defer_d = 1'b0;
            if (mode_q == MODE_ONESHOT) begin
               mode_d = MODE_OFF;
            end else if (limit_q != '0) begin
               count_d = limit_q;
            end else if (!policy_i[POL_CONT]) begin
               mode_d = MODE_OFF;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q   <= MODE_OFF;
         count_q  <= '0;
         limit_q  <= '0;
         period_q <= '0;
         defer_q  <= 1'b0;
         fire_q   <= 1'b0;
      end else begin
         mode_q   <= mode_d;
         count_q  <= count_d;
         limit_q  <= limit_d;
         period_q <= period_d;
         defer_q  <= defer_d;
         fire_q   <= fire_d;
      end
   end

   assign count_o   = count_q;
   assign mode_o    = mode_q;
   assign fire_o    = fire_q;
   assign run_o     = running;
   assign hold_o    = stop_i | start_i | count_we_i | limit_we_i | period_we_i;
   assign restart_o = restart;
   assign period_o  = period_q;

   // R14: input assumption, one strobe per cycle
   p_single_strobe_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({stop_i, start_i, count_we_i, limit_we_i, period_we_i}));

   // R11: input assumption, illegal policy pair never applied
   p_policy_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(policy_i[POL_LATE_TRIG] && policy_i[POL_DEC_ONLY]));

   // R11: no fire caused by a strobe under decrement-only
   p_dec_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i[POL_DEC_ONLY] && (start_i || count_we_i || limit_we_i)) |=> !fire_o);

   // R2: repeating expiry refills from the limit and fires
   p_refill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_PERIODIC && tick_i && count_q == ONE &&
       !policy_i[POL_DWELL] && limit_q != '0)
      |=> (count_q == $past(limit_q) && fire_o && mode_q == MODE_PERIODIC));

   // R3: single-shot expiry ends at zero, off, with a fire
   p_oneshot_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_ONESHOT && tick_i && count_q == ONE)
      |=> (mode_q == MODE_OFF && count_q == '0 && fire_o));

   // R7: dwell keeps a repeating timer at zero after reaching it
   p_dwell_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_PERIODIC && tick_i && count_q == ONE && policy_i[POL_DWELL])
      |=> (count_q == '0 && mode_q == MODE_PERIODIC));

   // R5: stop turns off and keeps the count
   p_stop_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (mode_q == MODE_OFF && count_q == $past(count_q)));

   // R6: start with a zero period has no effect
   p_zero_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MODE_OFF && start_i && period_q == '0) |=> (mode_q == MODE_OFF));

   // R13: period write keeps the count
   p_period_keeps_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_we_i |=> (count_q == $past(count_q)));

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PER_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [POL_W-1:0] policy_i,
   input  logic             limit_we_i,
   input  logic             limit_reload_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             count_we_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             start_i,
   input  logic             start_single_i,
   input  logic             stop_i,
   input  logic             period_we_i,
   input  logic [PER_W-1:0] period_i,
   output logic [CNT_W-1:0] count_o,
   output logic [1:0]       mode_o,
   output logic             fire_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("cdt_timer: CNT_W must be at least 2");
      end
      if (PER_W < 1 || PER_W > 32) begin : g_bad_per
         $error("cdt_timer: PER_W must be within 1..32");
      end
   endgenerate

   cdt_mode_e        mode;
   logic             tick, run, hold, restart;
   logic [PER_W-1:0] period;

   cdt_prescale #(.PER_W(PER_W)) pre_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .hold_i    (hold),
      .restart_i (restart),
      .period_i  (period),
      .tick_o    (tick)
   );

   cdt_core #(.CNT_W(CNT_W), .PER_W(PER_W)) core_i (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .policy_i       (policy_i),
      .limit_we_i     (limit_we_i),
      .limit_reload_i (limit_reload_i),
      .limit_i        (limit_i),
      .count_we_i     (count_we_i),
      .count_i        (count_i),
      .start_i        (start_i),
      .start_single_i (start_single_i),
      .stop_i         (stop_i),
      .period_we_i    (period_we_i),
      .period_i       (period_i),
      .tick_i         (tick),
      .count_o        (count_o),
      .mode_o         (mode),
      .fire_o         (fire_o),
      .run_o          (run),
      .hold_o         (hold),
      .restart_o      (restart),
      .period_o       (period)
   );

   assign mode_o = mode;

endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb_top;

   localparam int K_STOP = 0, K_START = 1, K_CNT = 2, K_LIM = 3, K_PER = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  policy = '0;
   logic        limit_we = 0, limit_reload = 0, count_we = 0;
   logic        start = 0, start_single = 0, stop = 0, period_we = 0;
   logic [15:0] limit_d = '0, count_d = '0;
   logic [7:0]  period_d = '0;
   logic [15:0] count_o;
   logic [1:0]  mode_o;
   logic        fire_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_cyc[$];
   string exp_tag[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cdt_timer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .policy_i(policy),
      .limit_we_i(limit_we), .limit_reload_i(limit_reload), .limit_i(limit_d),
      .count_we_i(count_we), .count_i(count_d),
      .start_i(start), .start_single_i(start_single), .stop_i(stop),
      .period_we_i(period_we), .period_i(period_d),
      .count_o(count_o), .mode_o(mode_o), .fire_o(fire_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic expect_fire(input int c, input string tag);
      exp_cyc.push_back(c);
      exp_tag.push_back(tag);
   endtask

   // scoreboard monitor for fire pulses
   always @(negedge clk) begin
      if (rst_n) begin
         if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
            checks++; errors++;
            $display("FAIL %s missed fire actual=none expected=%0d", exp_tag[0], exp_cyc[0]);
            void'(exp_cyc.pop_front());
            void'(exp_tag.pop_front());
         end
         if (fire_o) begin
            checks++;
            if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
               void'(exp_cyc.pop_front());
               void'(exp_tag.pop_front());
            end else begin
               errors++;
               $display("FAIL %s unexpected fire actual=%0d expected=%0d",
                        (exp_tag.size() > 0) ? exp_tag[0] : "R14",
                        cyc, (exp_cyc.size() > 0) ? exp_cyc[0] : -1);
            end
         end
      end
   end

   task automatic at(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // one strobe, taking effect at clock edge e
   task automatic ctl(input int e, input int k, input int d, input logic f);
      while (cyc < e - 1) @(negedge clk);
      case (k)
         K_STOP:  stop = 1'b1;
         K_START: begin start = 1'b1; start_single = f; end
         K_CNT:   begin count_we = 1'b1; count_d = 16'(d); end
         K_LIM:   begin limit_we = 1'b1; limit_reload = f; limit_d = 16'(d); end
         default: begin period_we = 1'b1; period_d = 8'(d); end
      endcase
      @(negedge clk);
      stop = 0; start = 0; start_single = 0; count_we = 0;
      limit_we = 0; limit_reload = 0; period_we = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int e, s;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 count", int'(count_o), 0);
      chk("R1 mode", int'(mode_o), 0);
      chk("R1 fire", int'(fire_o), 0);

      // repeating countdown, stop and resume
      s = cyc;
      ctl(s + 2, K_LIM, 4, 1'b1);
      ctl(s + 4, K_PER, 3, 1'b0);
      e = s + 6;
      expect_fire(e + 12, "R2"); expect_fire(e + 24, "R2");
      ctl(e, K_START, 0, 1'b0);
      at(e + 3);  chk("R2 first tick", int'(count_o), 3);
      at(e + 12); chk("R2 refill", int'(count_o), 4);
      ctl(e + 28, K_STOP, 0, 1'b0);
      chk("R5 mode off", int'(mode_o), 0);
      chk("R5 count kept", int'(count_o), 3);
      at(e + 35); chk("R5 count held", int'(count_o), 3);
      e = e + 37;
      expect_fire(e + 9, "R5");
      ctl(e, K_START, 0, 1'b0);
      at(e + 9);  chk("R5 resume", int'(count_o), 4);
      ctl(e + 10, K_STOP, 0, 1'b0);

      // single-shot
      s = cyc;
      ctl(s + 2, K_LIM, 2, 1'b1);
      ctl(s + 4, K_PER, 2, 1'b0);
      e = s + 6;
      expect_fire(e + 4, "R3");
      ctl(e, K_START, 0, 1'b1);
      chk("R3 mode single", int'(mode_o), 2);
      at(e + 4);  chk("R3 mode off", int'(mode_o), 0);
      chk("R3 count zero", int'(count_o), 0);
      at(e + 10); chk("R3 stays off", int'(mode_o), 0);

      // limit write with and without refill
      s = cyc;
      ctl(s + 2, K_CNT, 2, 1'b0);
      ctl(s + 4, K_LIM, 3, 1'b0);
      chk("R4 no refill", int'(count_o), 2);
      e = s + 6;
      expect_fire(e + 4, "R4");
      ctl(e, K_START, 0, 1'b0);
      at(e + 4);  chk("R4 new limit used", int'(count_o), 3);
      ctl(e + 5, K_STOP, 0, 1'b0);
      ctl(e + 7, K_LIM, 9, 1'b1);
      chk("R4 refill", int'(count_o), 9);

      // zero period
      s = cyc;
      ctl(s + 2, K_PER, 0, 1'b0);
      ctl(s + 4, K_START, 0, 1'b0);
      chk("R6 start ignored", int'(mode_o), 0);
      ctl(s + 6, K_PER, 2, 1'b0);
      ctl(s + 8, K_CNT, 5, 1'b0);
      ctl(s + 10, K_START, 0, 1'b0);
      chk("R6 running", int'(mode_o), 1);
      ctl(s + 11, K_PER, 0, 1'b0);
      at(s + 12); chk("R6 self off", int'(mode_o), 0);
      chk("R6 count kept", int'(count_o), 5);

      // dwell policy
      policy = 5'b00001;
      s = cyc;
      ctl(s + 2, K_LIM, 2, 1'b1);
      ctl(s + 4, K_PER, 2, 1'b0);
      e = s + 6;
      expect_fire(e + 4, "R7"); expect_fire(e + 10, "R7");
      ctl(e, K_START, 0, 1'b0);
      at(e + 5);  chk("R7 dwell at zero", int'(count_o), 0);
      chk("R7 still running", int'(mode_o), 1);
      at(e + 6);  chk("R7 refill after dwell", int'(count_o), 2);
      ctl(e + 11, K_STOP, 0, 1'b0);

      // continuous policy with zero limit
      policy = 5'b00010;
      s = cyc;
      ctl(s + 2, K_LIM, 0, 1'b1);
      ctl(s + 4, K_PER, 3, 1'b0);
      e = s + 6;
      expect_fire(e, "R8"); expect_fire(e + 3, "R8");
      expect_fire(e + 6, "R8"); expect_fire(e + 9, "R8");
      ctl(e, K_START, 0, 1'b0);
      at(e + 1);  chk("R8 stays on", int'(mode_o), 1);
      ctl(e + 10, K_STOP, 0, 1'b0);

      // no policy, zero arm
      policy = 5'b00000;
      e = cyc + 2;
      expect_fire(e, "R12");
      ctl(e, K_START, 0, 1'b0);
      chk("R12 off on zero limit", int'(mode_o), 0);
      s = cyc;
      ctl(s + 2, K_LIM, 3, 1'b0);
      e = s + 4;
      expect_fire(e, "R12"); expect_fire(e + 9, "R12");
      ctl(e, K_START, 0, 1'b0);
      chk("R12 immediate refill", int'(count_o), 3);
      ctl(e + 10, K_STOP, 0, 1'b0);

      // late fire policy
      policy = 5'b00100;
      s = cyc;
      ctl(s + 2, K_CNT, 0, 1'b0);
      ctl(s + 4, K_PER, 2, 1'b0);
      e = s + 6;
      expect_fire(e + 2, "R9"); expect_fire(e + 8, "R9");
      ctl(e, K_START, 0, 1'b0);
      at(e + 1);  chk("R9 held zero", int'(count_o), 0);
      chk("R9 running", int'(mode_o), 1);
      at(e + 2);  chk("R9 refill", int'(count_o), 3);
      ctl(e + 9, K_STOP, 0, 1'b0);

      // late refill policy
      policy = 5'b01000;
      s = cyc;
      ctl(s + 2, K_CNT, 0, 1'b0);
      e = s + 4;
      expect_fire(e, "R10"); expect_fire(e + 8, "R10");
      ctl(e, K_START, 0, 1'b0);
      at(e + 1);  chk("R10 held zero", int'(count_o), 0);
      at(e + 2);  chk("R10 refill", int'(count_o), 3);
      ctl(e + 9, K_STOP, 0, 1'b0);

      // decrement-only policy
      policy = 5'b10000;
      s = cyc;
      ctl(s + 2, K_CNT, 0, 1'b0);
      e = s + 4;
      expect_fire(e + 7, "R11");
      ctl(e, K_START, 0, 1'b0);
      chk("R11 start refill", int'(count_o), 3);
      ctl(e + 1, K_CNT, 0, 1'b0);
      chk("R11 write refill", int'(count_o), 3);
      ctl(e + 8, K_STOP, 0, 1'b0);

      // period change while running
      policy = 5'b00000;
      s = cyc;
      ctl(s + 2, K_LIM, 9, 1'b1);
      ctl(s + 4, K_PER, 4, 1'b0);
      e = s + 6;
      ctl(e, K_START, 0, 1'b0);
      at(e + 4);  chk("R13 before change", int'(count_o), 8);
      ctl(e + 6, K_PER, 2, 1'b0);
      at(e + 7);  chk("R13 count kept", int'(count_o), 8);
      at(e + 8);  chk("R13 new period", int'(count_o), 7);
      ctl(e + 9, K_STOP, 0, 1'b0);

      // strobe on a tick edge
      s = cyc;
      ctl(s + 2, K_LIM, 5, 1'b1);
      ctl(s + 4, K_PER, 4, 1'b0);
      e = s + 6;
      expect_fire(e + 12, "R14");
      ctl(e, K_START, 0, 1'b0);
      ctl(e + 4, K_CNT, 2, 1'b0);
      chk("R14 write wins", int'(count_o), 2);
      at(e + 12); chk("R14 refill", int'(count_o), 5);
      at(e + 13); chk("R14 single pulse", int'(fire_o), 0);
      ctl(e + 14, K_STOP, 0, 1'b0);

      repeat (5) @(negedge clk);
      chk("R2 scoreboard drained", exp_cyc.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule